// File: doc/BRIEF.md
# DMA Register Bank with Masked Interrupt

This block is the software-facing register file of a DMA engine. A processor reaches it over an APB-style two-phase access. It holds the engine's enable bits and the address of the channel list, and shows live engine state: the active channel, the codes of the bus and control sequencers, and the address the engine is working on.

Two engine pulses feed sticky interrupt flags. One marks a finished descriptor and the other marks a bus error. Each flag is gated by its bit in a 32-bit mask register, and the gated flags are ORed into a single interrupt line. A bus error also turns the controller off by clearing its enable bit.

Top module: `dma_regbank`

## Requirements
- R1: After reset every stored register is zero, so `dma_en`, `chan_en` and `irq` are low and `base_addr` is zero.
- R2: A write lands only at the clock edge of an enable cycle, where `psel`, `penable` and `pwrite` are all high. A setup cycle that is not followed by an enable cycle changes nothing.
- R3: The word at offset 0x00 is read-only. Bits [8:6] give the active channel (0 means none, 1 to 7 is the channel number), bits [5:4] give the bus sequencer code and bits [3:0] give the control sequencer code (0 to 10). All other bits read zero.
- R4: At offset 0x04, bit 0 is the controller enable and drives `dma_en`. Bit 1 is the channel-enable indication and drives `chan_en`. Bits [31:2] are discarded on write and read as zero.
- R5: Offset 0x08 holds a 32-bit base address that reads back as written and drives `base_addr`.
- R6: Offset 0x0C reads the live `eng_cur_addr`. Writes to 0x00 or 0x0C have no effect.
- R7: A pulse on `eng_desc_done` sets interrupt bit 0 and a pulse on `eng_bus_err` sets interrupt bit 1. Both bits are read at offset 0x10 and stay set until cleared.
- R8: Writing 1 to an interrupt bit clears it, and writing 0 leaves it alone. An engine set in the same cycle as a clear wins.
- R9: Offset 0x14 holds a 32-bit mask that reads back in full. `irq` is high exactly when some interrupt bit and its mask bit are both 1.
- R10: A bus-error pulse clears control bit 0. This holds even when a control write in the same cycle sets that bit, while control bit 1 takes the written value.
- R11: Any other offset, including addresses that are not word aligned, reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Access select, high in setup and enable cycles |
| penable | input | 1 | High in the second (enable) cycle of an access |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| eng_chan | input | 3 | Active channel from the engine |
| eng_bus_st | input | 2 | Bus sequencer code |
| eng_ctl_st | input | 4 | Control sequencer code |
| eng_cur_addr | input | 32 | Address the engine is working on |
| eng_desc_done | input | 1 | One-cycle pulse on descriptor completion |
| eng_bus_err | input | 1 | One-cycle pulse on an error, retry or split response |
| dma_en | output | 1 | Controller enable |
| chan_en | output | 1 | Channel-enable indication |
| base_addr | output | 32 | Channel list base address |
| irq | output | 1 | Masked interrupt to the processor |

## Verification
The assertions assume the access protocol is well formed. `penable` is never high without `psel`, and every enable cycle follows a cycle in which `psel` was already high. The bench drives each access as exactly one setup cycle followed by one enable cycle, so it stays within these rules. It also forces a single setup cycle with no enable cycle, which the protocol allows and which must not write anything. The engine inputs are driven only between accesses, or held across a whole access when the same-cycle priority rules of R8 and R10 are being tested.

// File: rtl/dma_regbank_pkg.sv
// Shared slot numbering for the DMA register bank. Each slot sits at
// byte offset slot*4.
package dma_regbank_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int SLOT_STATUS = 0;
    localparam int SLOT_CTRL   = 1;
    localparam int SLOT_BASE   = 2;
    localparam int SLOT_CUR    = 3;
    localparam int SLOT_INTR   = 4;
    localparam int SLOT_MASK   = 5;
endpackage

// File: rtl/dma_slot_decode.sv
// Decodes the two-phase access into per-slot write and read strobes.
// Assumes the access protocol is well formed: penable only with psel,
// and every enable cycle preceded by a selected setup cycle.
module dma_slot_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_SLOTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    output logic [NUM_SLOTS-1:0] wr_hit,
    output logic [NUM_SLOTS-1:0] rd_hit
);
    // One comparator per slot; a write strobes only in the enable cycle.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic match;
        assign match     = (paddr == ADDR_W'(i * 4));
        assign wr_hit[i] = psel && penable && pwrite && match;
        assign rd_hit[i] = psel && !pwrite && match;
    end

    // R2
    enable_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);
    // R2
    setup_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(penable) |-> $past(psel));
endmodule

// File: rtl/dma_ctrl_regs.sv
// Holds the control bits, the channel-list base and the interrupt mask.
// A bus error overrides a same-cycle write to the controller enable bit.
module dma_ctrl_regs #(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_base,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bus_err,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] mask_q
);
    // Control bits: software write, then the error clear of bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            if (bus_err) ctrl_q[0] <= 1'b0;
        end
    end

    // Base address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (wr_base) base_q <= wdata;
    end

    // Full-width mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    // R10
    err_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !ctrl_q[0]);
    // R5
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_base |=> $stable(base_q));
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/dma_irq_flags.sv
// Sticky interrupt flags with write-one-to-clear and set priority, plus
// the masked OR that forms the interrupt line.
module dma_irq_flags #(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic               clr_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  mask,
    output logic [NUM_IRQ-1:0] flags_q,
    output logic               irq
);
    logic [NUM_IRQ-1:0] clr_vec;

    // Bits to clear this cycle.
    always_comb clr_vec = clr_wr ? wdata[NUM_IRQ-1:0] : '0;

    // Flag update: clear first, then the engine sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    // Masked interrupt line.
    always_comb irq = |(flags_q & mask[NUM_IRQ-1:0]);

    // R7
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags_q & $past(wdata[NUM_IRQ-1:0] & ~set_vec)) == '0));
    // R7
    rise_only_by_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/dma_regbank.sv
// Register bank of a DMA engine: decodes accesses, stores the control,
// base and mask registers and the interrupt flags, and packs the live
// engine state into the status word. Read data is combinational.
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CHAN_W   = 3,
    parameter int BUS_ST_W = 2,
    parameter int CTL_ST_W = 4,
    parameter int NUM_IRQ  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    input  logic [CHAN_W-1:0]   eng_chan,
    input  logic [BUS_ST_W-1:0] eng_bus_st,
    input  logic [CTL_ST_W-1:0] eng_ctl_st,
    input  logic [DATA_W-1:0]   eng_cur_addr,
    input  logic                eng_desc_done,
    input  logic                eng_bus_err,
    output logic                dma_en,
    output logic                chan_en,
    output logic [DATA_W-1:0]   base_addr,
    output logic                irq
);
    localparam int CTRL_W   = 2;
    localparam int STATUS_W = CHAN_W + BUS_ST_W + CTL_ST_W;

    logic [NUM_SLOTS-1:0] wr_hit;
    logic [NUM_SLOTS-1:0] rd_hit;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [DATA_W-1:0]    mask_q;
    logic [NUM_IRQ-1:0]   flags_q;
    logic [NUM_IRQ-1:0]   set_vec;
    logic [DATA_W-1:0]    slot_word [NUM_SLOTS];

    dma_slot_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    dma_ctrl_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_hit[SLOT_CTRL]), .wr_base(wr_hit[SLOT_BASE]),
        .wr_mask(wr_hit[SLOT_MASK]), .wdata(pwdata), .bus_err(eng_bus_err),
        .ctrl_q(ctrl_q), .base_q(base_addr), .mask_q(mask_q)
    );

    // Engine event vector: bit 0 descriptor done, bit 1 bus error.
    always_comb begin
        set_vec    = '0;
        set_vec[0] = eng_desc_done;
        set_vec[1] = eng_bus_err;
    end

    dma_irq_flags #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_wr(wr_hit[SLOT_INTR]), .wdata(pwdata), .mask(mask_q),
        .flags_q(flags_q), .irq(irq)
    );

    // Enable outputs straight from the control bits.
    always_comb begin
        dma_en  = ctrl_q[0];
        chan_en = ctrl_q[1];
    end

    // Per-slot read words; status is packed live from the engine.
    always_comb begin
        slot_word[SLOT_STATUS] = DATA_W'({eng_chan, eng_bus_st, eng_ctl_st});
        slot_word[SLOT_CTRL]   = DATA_W'(ctrl_q);
        slot_word[SLOT_BASE]   = base_addr;
        slot_word[SLOT_CUR]    = eng_cur_addr;
        slot_word[SLOT_INTR]   = DATA_W'(flags_q);
        slot_word[SLOT_MASK]   = mask_q;
    end

    // Read mux: OR of the selected slot, zero when nothing matches.
    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (rd_hit[i]) prdata = prdata | slot_word[i];
    end

    // R9
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_hit[SLOT_INTR] || wr_hit[SLOT_MASK]));
    // R3
    status_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit[SLOT_STATUS] |-> (prdata >> STATUS_W) == '0);
endmodule

// File: tb/dma_regbank_test.sv
module dma_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [2:0]  eng_chan = '0;
    logic [1:0]  eng_bus_st = '0;
    logic [3:0]  eng_ctl_st = '0;
    logic [31:0] eng_cur_addr = '0;
    logic        eng_desc_done = 1'b0, eng_bus_err = 1'b0;
    logic        dma_en, chan_en, irq;
    logic [31:0] base_addr;

    int n_chk = 0;
    int n_bad = 0;

    dma_regbank uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .eng_chan(eng_chan), .eng_bus_st(eng_bus_st), .eng_ctl_st(eng_ctl_st),
        .eng_cur_addr(eng_cur_addr), .eng_desc_done(eng_desc_done),
        .eng_bus_err(eng_bus_err), .dma_en(dma_en), .chan_en(chan_en),
        .base_addr(base_addr), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic pulse(input bit done, input bit err);
        @(negedge clk); eng_desc_done = done; eng_bus_err = err;
        @(negedge clk); eng_desc_done = 0; eng_bus_err = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 dma_en", {30'b0, chan_en, dma_en}, 32'h0);
        check("R1 base", base_addr, 32'h0);

        // R3 status packing sweep
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < 4; b++)
                for (int s = 0; s <= 10; s++) begin
                    eng_chan = 3'(c); eng_bus_st = 2'(b); eng_ctl_st = 4'(s);
                    rd(8'h00, v);
                    check("R3 status", v, 32'(c * 64 + b * 16 + s));
                end

        // R4 control bits
        for (int k = 0; k < 4; k++) begin
            wr(8'h04, 32'hABCDEF00 | 32'(k) | 32'hFFFFFFFC);
            rd(8'h04, v);
            check("R4 ctrl read", v, 32'(k));
            check("R4 outputs", {30'b0, chan_en, dma_en}, 32'(k));
        end

        // R5 base address
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = 32'h1234_5678 ^ (32'hF0F0_0F0F << k);
            wr(8'h08, pat);
            rd(8'h08, v);
            check("R5 base read", v, pat);
            check("R5 base out", base_addr, pat);
        end

        // R2 setup without enable must not write
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 8'h08; pwdata = 32'hDEAD_BEEF;
        @(negedge clk); psel = 0; pwrite = 0;
        rd(8'h08, v);
        check("R2 no write", v, 32'h1234_5678 ^ (32'hF0F0_0F0F << 3));

        // R6 current address live and read-only; status not writable
        eng_cur_addr = 32'h8000_0040;
        rd(8'h0C, v);
        check("R6 cur", v, 32'h8000_0040);
        wr(8'h0C, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        eng_cur_addr = 32'h0000_1FFC;
        rd(8'h0C, v);
        check("R6 cur after write", v, 32'h0000_1FFC);
        eng_chan = 3'd2; eng_bus_st = 2'd1; eng_ctl_st = 4'd6;
        rd(8'h00, v);
        check("R6 status after write", v, 32'(2 * 64 + 16 + 6));

        // R7 R9 mask and flag sweep (R10 clears enable on each error)
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++) begin
                logic [31:0] mw;
                mw = 32'h5A5A_0000 | 32'(m);
                wr(8'h10, 32'h3);
                wr(8'h14, mw);
                pulse(f[0], f[1]);
                rd(8'h10, v);
                check("R7 flags", v, 32'(f));
                check("R9 irq", {31'b0, irq}, {31'b0, |(f[1:0] & m[1:0])});
                rd(8'h14, v);
                check("R9 mask read", v, mw);
            end

        // R8 write-one-to-clear, selective
        wr(8'h14, 32'h3);
        pulse(1, 1);
        wr(8'h10, 32'h2);
        rd(8'h10, v);
        check("R8 clear bit1 only", v, 32'h1);
        check("R8 irq kept", {31'b0, irq}, 32'h1);
        wr(8'h10, 32'h1);
        rd(8'h10, v);
        check("R8 cleared", v, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);

        // R8 set wins over same-cycle clear
        @(negedge clk); eng_desc_done = 1;
        wr(8'h10, 32'h1);
        eng_desc_done = 0;
        rd(8'h10, v);
        check("R8 set priority", v, 32'h1);
        wr(8'h10, 32'h3);

        // R10 error clears enable
        wr(8'h04, 32'h3);
        pulse(0, 1);
        check("R10 dma_en cleared", {30'b0, chan_en, dma_en}, 32'h2);
        // R10 error beats a same-cycle enable write
        wr(8'h04, 32'h0);
        @(negedge clk); eng_bus_err = 1;
        wr(8'h04, 32'h3);
        eng_bus_err = 0;
        rd(8'h04, v);
        check("R10 concurrent", v, 32'h2);

        // R11 unmapped offsets
        wr(8'h04, 32'h1);
        wr(8'h08, 32'hCAFE_0004);
        wr(8'h14, 32'h0000_0001);
        wr(8'h10, 32'h3);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ua;
            ua = (k < 4) ? 8'(8'h18 + k * 4) : ((k == 4) ? 8'h09 : 8'hFC);
            wr(ua, 32'hFFFF_FFFF);
            rd(ua, v);
            check("R11 unmapped read", v, 32'h0);
        end
        rd(8'h04, v); check("R11 ctrl kept", v, 32'h1);
        rd(8'h08, v); check("R11 base kept", v, 32'hCAFE_0004);
        rd(8'h14, v); check("R11 mask kept", v, 32'h1);
        rd(8'h10, v); check("R11 flags kept", v, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule